// File: doc/BRIEF.md
# Center-Aligned PWM Timer Channel

This block is a general-purpose up/down timer with a single compare channel that produces a pulse-width modulated pin. A prescaler divides the clock into counter ticks. The counter then runs in one of four alignment modes. In edge mode it counts in one direction and wraps. In the three center modes it sweeps up to the reload value and back down to zero. Every wrap is an overflow or underflow event. A repetition counter passes only some of these events on as update events.

Configuration arrives as plain input fields that software-visible registers would drive. The reload value can be taken directly, or held in a shadow copy until the next update. A software update strobe forces an update at once. It copies the prescaler, reload and repetition values into the active set and restarts the counter. The compare channel raises a one-cycle flag when the counter steps onto the compare value. The alignment mode decides which stepping directions may raise it. The pin follows the selected output mode and is driven only while both the channel enable and the master output enable are set.

Top module: `pwm_timer`

## Requirements
- R1: With alignment 00 and direction 0, the counter takes the values 0, 1, …, ARR and then wraps to 0, so one period is ARR+1 ticks. Each wrap is an overflow event.
- R2: With alignment 00 and direction 1, the counter takes the values ARR, ARR−1, …, 0 and then reloads ARR, so one period is ARR+1 ticks. Each reload is an underflow event.
- R3: With alignment 01, 10 or 11 and ARR ≥ 1, the counter climbs from 0 to ARR and then falls back to 0, so one period is 2·ARR ticks. Arriving at ARR is an overflow event and arriving at 0 is an underflow event. `dir_status` reads 1 from arrival at ARR until arrival at 0, and 0 otherwise. In edge mode it reads the direction input.
- R4: The counter advances once every PSC+1 enabled clocks. While `cnt_en` is 0, both the counter and the prescaler phase hold their values, and counting resumes from where it stopped.
- R5: `cc_flag` is high for one cycle after a tick that moves the counter onto CMP. Whether the step may raise the flag depends on the alignment: 00 and 11 allow steps in either direction, 01 allows only downward steps, and 10 allows only upward steps. A downward step is any step whose new value is below the old one. In edge mode the step direction is the direction input.
- R6: The output mode is a 4-bit code. 0110 drives the reference active while the counter is below CMP. 0111 is the inverse of 0110. 0100 forces the reference inactive and 0101 forces it active. Every other code is inactive.
- R7: `pwm_out` equals the reference only when `ch_en` and `moe` are both 1. Otherwise it is 0.
- R8: With repetition value N, `upd_flag` pulses on every (N+1)-th overflow or underflow event counted since the last update.
- R9: With `arr_preload` at 1, a new ARR takes effect only at the next update event. With `arr_preload` at 0, it takes effect on the next tick.
- R10: A one-cycle `ug` pulse produces `upd_flag` in the next cycle. It restarts the counter at 0 (at ARR in edge-down mode), clears the prescaler phase and reloads the repetition count, and it raises no `cc_flag`.
- R11: After reset, `cnt_out`, `dir_status`, `cc_flag`, `upd_flag` and `pwm_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counter and prescaler run enable |
| cnt_dir | input | 1 | Edge-mode direction, 0 up, 1 down |
| align_mode | input | 2 | 00 edge, 01 center/flag down, 10 center/flag up, 11 center/flag both |
| psc_val | input | PSC_W | Prescaler divide value minus one |
| arr_val | input | CNT_W | Reload value |
| arr_preload | input | 1 | Shadow the reload value until an update |
| rep_val | input | REP_W | Repetition value N |
| cmp_val | input | CNT_W | Compare value |
| oc_mode | input | 4 | Output mode code |
| ch_en | input | 1 | Channel output enable |
| moe | input | 1 | Master output enable |
| ug | input | 1 | Software update strobe |
| cnt_out | output | CNT_W | Counter value |
| dir_status | output | 1 | Current count direction |
| cc_flag | output | 1 | Compare match pulse |
| upd_flag | output | 1 | Update event pulse |
| pwm_out | output | 1 | Channel pin |

## Verification
The main sweep runs every alignment mode over small reload values from 0 to 5, prescaler divides of 1 to 3, repetition values of 0 to 2, and compare values at zero, mid-range and the top. Each expected counter value is computed from the tick index as a modulus or a triangle fold. Comparing the flag and pin in every cycle separates the edge and center trajectories and both wrap directions. It also separates the per-direction flag gating of the three center modes and the update decimation. Targeted runs cover the remaining cases. A reload write with and without preload tells shadowed from immediate reload. A counter disable in the middle of a prescale tells a frozen phase from a cleared one. A restart with a compare value of 0 tells an update restart from a counted step. The gating combinations and forced output codes cover the pin.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

   typedef enum logic [1:0] {
      ALIGN_EDGE  = 2'b00,
      ALIGN_CDOWN = 2'b01,
      ALIGN_CUP   = 2'b10,
      ALIGN_CBOTH = 2'b11
   } align_e;

   localparam logic [3:0] OCM_FORCE_LO = 4'b0100;
   localparam logic [3:0] OCM_FORCE_HI = 4'b0101;
   localparam logic [3:0] OCM_PWM1     = 4'b0110;
   localparam logic [3:0] OCM_PWM2     = 4'b0111;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PSC_W-1:0] div,
   output logic             tick
);

   logic [PSC_W-1:0] phase_q;
   logic             at_end;

   assign at_end = (phase_q >= div);
   assign tick   = run & ~restart & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (restart) begin
         phase_q <= '0;
      end else if (run) begin
         phase_q <= at_end ? '0 : phase_q + 1'b1;
      end
   end

   // R4
   psc_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !restart) |=> $stable(phase_q));

endmodule

// File: rtl/tmr_reload_regs.sv
module tmr_reload_regs #(
   parameter int CNT_W = 16,
   parameter int PSC_W = 16,
   parameter int REP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_upd,
   input  logic             wrap_ev,
   input  logic             arr_pre_en,
   input  logic [PSC_W-1:0] psc_in,
   input  logic [CNT_W-1:0] arr_in,
   input  logic [REP_W-1:0] rep_in,
   output logic [PSC_W-1:0] psc_act,
   output logic [CNT_W-1:0] arr_eff,
   output logic             update
);

   logic [CNT_W-1:0] arr_sh;
   logic [REP_W-1:0] rep_left;

   assign update  = sw_upd | (wrap_ev & (rep_left == '0));
   assign arr_eff = arr_pre_en ? arr_sh : arr_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_act  <= '0;
         arr_sh   <= '1;
         rep_left <= '0;
      end else if (update) begin
         psc_act  <= psc_in;
         arr_sh   <= arr_in;
         rep_left <= rep_in;
      end else if (wrap_ev) begin
         rep_left <= rep_left - 1'b1;
      end
   end

   // R9
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !update |=> $stable(arr_sh));

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
   import pwm_timer_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   input  align_e           align,
   input  logic             dir_in,
   input  logic [CNT_W-1:0] arr_eff,
   input  logic [CNT_W-1:0] arr_in,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             step_up,
   output logic             wrap_ev,
   output logic             cdir
);

   logic center;
   logic wrap_c;
   logic dir_nxt;

   assign center = (align != ALIGN_EDGE);

   always_comb begin
      cnt_nxt = cnt;
      dir_nxt = cdir;
      wrap_c  = 1'b0;
      step_up = 1'b0;
      if (!center) begin
         dir_nxt = dir_in;
         step_up = ~dir_in;
         if (!dir_in) begin
            if (cnt >= arr_eff) begin
               cnt_nxt = '0;
               wrap_c  = 1'b1;
            end else begin
               cnt_nxt = cnt + 1'b1;
            end
         end else begin
            if (cnt == '0) begin
               cnt_nxt = arr_eff;
               wrap_c  = 1'b1;
            end else begin
               cnt_nxt = cnt - 1'b1;
            end
         end
      end else if (arr_eff == '0) begin
         cnt_nxt = '0;
         dir_nxt = 1'b0;
         wrap_c  = 1'b1;
      end else if (!cdir) begin
         step_up = 1'b1;
         if (cnt >= arr_eff - 1'b1) begin
            cnt_nxt = arr_eff;
            dir_nxt = 1'b1;
            wrap_c  = 1'b1;
         end else begin
            cnt_nxt = cnt + 1'b1;
         end
      end else begin
         if (cnt <= {{(CNT_W-1){1'b0}}, 1'b1}) begin
            cnt_nxt = '0;
            dir_nxt = 1'b0;
            wrap_c  = 1'b1;
         end else begin
            cnt_nxt = cnt - 1'b1;
         end
      end
   end

   assign wrap_ev = tick & wrap_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         cdir <= 1'b0;
      end else if (restart) begin
         cnt  <= (!center && dir_in) ? arr_in : '0;
         cdir <= center ? 1'b0 : dir_in;
      end else if (tick) begin
         cnt  <= cnt_nxt;
         cdir <= dir_nxt;
      end else if (!center) begin
         cdir <= dir_in;
      end
   end

   // R1
   edge_up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && align == ALIGN_EDGE && !dir_in && cnt < arr_eff)
      |=> cnt == $past(cnt) + 1'b1);

   // R3
   center_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && center && cdir && cnt == arr_eff && arr_eff > 1)
      |=> (cnt < $past(cnt)));

endmodule

// File: rtl/tmr_compare_out.sv
module tmr_compare_out
   import pwm_timer_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             step_up,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic [CNT_W-1:0] ccr,
   input  logic [3:0]       oc_mode,
   input  align_e           align,
   input  logic             ch_en,
   input  logic             moe,
   output logic             cc_flag,
   output logic             pwm_out
);

   logic dir_ok;
   logic below;
   logic oc_ref;

   always_comb begin
      unique case (align)
         ALIGN_CDOWN: dir_ok = ~step_up;
         ALIGN_CUP:   dir_ok = step_up;
         default:     dir_ok = 1'b1;
      endcase
   end

   assign below = (cnt < ccr);

   always_comb begin
      unique case (oc_mode)
         OCM_FORCE_LO: oc_ref = 1'b0;
         OCM_FORCE_HI: oc_ref = 1'b1;
         OCM_PWM1:     oc_ref = below;
         OCM_PWM2:     oc_ref = ~below;
         default:      oc_ref = 1'b0;
      endcase
   end

   assign pwm_out = ch_en & moe & oc_ref;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cc_flag <= 1'b0;
      else        cc_flag <= step & dir_ok & (cnt_nxt == ccr);
   end

   // R5
   cc_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cc_flag |-> cnt == $past(ccr));

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
   import pwm_timer_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PSC_W = 16,
   parameter int REP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             cnt_dir,
   input  logic [1:0]       align_mode,
   input  logic [PSC_W-1:0] psc_val,
   input  logic [CNT_W-1:0] arr_val,
   input  logic             arr_preload,
   input  logic [REP_W-1:0] rep_val,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [3:0]       oc_mode,
   input  logic             ch_en,
   input  logic             moe,
   input  logic             ug,
   output logic [CNT_W-1:0] cnt_out,
   output logic             dir_status,
   output logic             cc_flag,
   output logic             upd_flag
   ,
   output logic             pwm_out
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
         $error("pwm_timer: CNT_W must lie in 2..32");
      end
      if (PSC_W < 1 || PSC_W > 32) begin : g_bad_psc_w
         $error("pwm_timer: PSC_W must lie in 1..32");
      end
      if (REP_W < 1 || REP_W > 16) begin : g_bad_rep_w
         $error("pwm_timer: REP_W must lie in 1..16");
      end
   endgenerate

   align_e           align;
   logic             tick;
   logic             wrap_ev;
   logic             update;
   logic             step_up;
   logic [PSC_W-1:0] psc_act;
   logic [CNT_W-1:0] arr_eff;
   logic [CNT_W-1:0] cnt_nxt;

   assign align = align_e'(align_mode);

   tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (cnt_en),
      .restart (ug),
      .div     (psc_act),
      .tick    (tick)
   );

   tmr_reload_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .REP_W(REP_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_upd     (ug),
      .wrap_ev    (wrap_ev),
      .arr_pre_en (arr_preload),
      .psc_in     (psc_val),
      .arr_in     (arr_val),
      .rep_in     (rep_val),
      .psc_act    (psc_act),
      .arr_eff    (arr_eff),
      .update     (update)
   );

   tmr_count_core #(.CNT_W(CNT_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (ug),
      .tick    (tick),
      .align   (align),
      .dir_in  (cnt_dir),
      .arr_eff (arr_eff),
      .arr_in  (arr_val),
      .cnt     (cnt_out),
      .cnt_nxt (cnt_nxt),
      .step_up (step_up),
      .wrap_ev (wrap_ev),
      .cdir    (dir_status)
   );

   tmr_compare_out #(.CNT_W(CNT_W)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (tick),
      .step_up (step_up),
      .cnt     (cnt_out),
      .cnt_nxt (cnt_nxt),
      .ccr     (cmp_val),
      .oc_mode (oc_mode),
      .align   (align),
      .ch_en   (ch_en),
      .moe     (moe),
      .cc_flag (cc_flag),
      .pwm_out (pwm_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upd_flag <= 1'b0;
      else        upd_flag <= update;
   end

   // R10
   sw_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ug |=> (upd_flag && !cc_flag));

   // R7
   pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(moe) && !moe) |-> !pwm_out);

endmodule

// File: tb/pwm_timer_tb.sv
module pwm_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0;
   logic        cnt_dir = 1'b0;
   logic [1:0]  align_mode = 2'b00;
   logic [15:0] psc_val = '0;
   logic [15:0] arr_val = '0;
   logic        arr_preload = 1'b0;
   logic [7:0]  rep_val = '0;
   logic [15:0] cmp_val = '0;
   logic [3:0]  oc_mode = 4'b0000;
   logic        ch_en = 1'b0;
   logic        moe = 1'b0;
   logic        ug = 1'b0;
   logic [15:0] cnt_out;
   logic        dir_status;
   logic        cc_flag;
   logic        upd_flag;
   logic        pwm_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pwm_timer u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_dir(cnt_dir),
      .align_mode(align_mode), .psc_val(psc_val), .arr_val(arr_val),
      .arr_preload(arr_preload), .rep_val(rep_val), .cmp_val(cmp_val),
      .oc_mode(oc_mode), .ch_en(ch_en), .moe(moe), .ug(ug),
      .cnt_out(cnt_out), .dir_status(dir_status), .cc_flag(cc_flag),
      .upd_flag(upd_flag), .pwm_out(pwm_out)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   // Apply configuration and pulse the update strobe; returns at the negedge after it.
   task automatic start(int al, int dr, int p, int a, int r, int c, bit pre);
      align_mode = al[1:0]; cnt_dir = dr[0]; psc_val = p[15:0]; arr_val = a[15:0];
      rep_val = r[7:0]; cmp_val = c[15:0]; oc_mode = 4'b0110; ch_en = 1'b1; moe = 1'b1;
      arr_preload = pre; cnt_en = 1'b1; ug = 1'b1;
      cyc();
      ug = 1'b0;
   endtask

   task automatic run_sweep(int al, int dr, int p, int a, int r, int c);
      int per, n;
      string rq;
      per = (al == 0) ? (a + 1) : (2 * a);
      n = (p + 1) * (per * (r + 1) + 2);
      rq = (al != 0) ? "R3" : (dr != 0 ? "R2" : "R1");
      start(al, dr, p, a, r, c, 1'b1);
      chk("R10", "restart value", int'(cnt_out), (al == 0 && dr != 0) ? a : 0);
      chk("R10", "restart update flag", int'(upd_flag), 1);
      chk("R10", "restart compare flag", int'(cc_flag), 0);
      for (int j = 1; j <= n; j++) begin
         int k, ph, ecnt, ncnt, up, edir, ok;
         bit tk, ev;
         cyc();
         k  = j / (p + 1);
         tk = (j % (p + 1)) == 0;
         if (al == 0) begin
            ph   = k % (a + 1);
            ecnt = (dr != 0) ? (a - ph) : ph;
            ev   = tk && k > 0 && ph == 0;
            ncnt = k / (a + 1);
            up   = (dr == 0);
            edir = dr;
         end else begin
            ph   = k % (2 * a);
            ecnt = (ph <= a) ? ph : (2 * a - ph);
            ev   = tk && k > 0 && (k % a) == 0;
            ncnt = k / a;
            up   = (ph >= 1 && ph <= a);
            edir = (ph >= a) ? 1 : 0;
         end
         ok = (al == 1) ? !up : (al == 2) ? up : 1;
         chk(rq, "counter", int'(cnt_out), ecnt);
         chk(rq, "direction status", int'(dir_status), edir);
         chk("R5", "compare flag", int'(cc_flag), (tk && ecnt == c && ok != 0) ? 1 : 0);
         chk("R8", "update flag", int'(upd_flag), (ev && (ncnt % (r + 1)) == 0) ? 1 : 0);
         chk("R6", "pwm1 pin", int'(pwm_out), (ecnt < c) ? 1 : 0);
         if (p > 0) chk("R4", "prescaled counter", int'(cnt_out), ecnt);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int exp_pre[9];
      int exp_imm[6];
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11", "counter", int'(cnt_out), 0);
      chk("R11", "dir status", int'(dir_status), 0);
      chk("R11", "cc flag", int'(cc_flag), 0);
      chk("R11", "upd flag", int'(upd_flag), 0);
      chk("R11", "pin", int'(pwm_out), 0);
      rst_n = 1'b1;
      cyc();

      // Sweeps over modes, reload, prescale, repetition, compare
      for (int al = 0; al < 4; al++) begin
         for (int dr = 0; dr < ((al == 0) ? 2 : 1); dr++) begin
            for (int a = (al == 0) ? 0 : 1; a <= 5; a++) begin
               for (int p = 0; p < 3; p++) begin
                  for (int r = 0; r < 3; r++) begin
                     for (int cs = 0; cs < 3; cs++) begin
                        int c;
                        c = (cs == 0) ? 0 : (cs == 1) ? (a + 1) / 2 : a;
                        run_sweep(al, dr, p, a, r, c);
                     end
                  end
               end
            end
         end
      end

      // R9 preloaded reload: old value runs until the wrap update
      exp_pre = '{3, 4, 5, 0, 1, 2, 0, 1, 2};
      start(0, 0, 0, 5, 0, 0, 1'b1);
      cyc(); cyc();
      chk("R9", "pre-write count", int'(cnt_out), 2);
      arr_val = 16'd2;
      for (int i = 0; i < 9; i++) begin
         cyc();
         chk("R9", "preloaded reload", int'(cnt_out), exp_pre[i]);
      end

      // R9 immediate reload
      exp_imm = '{0, 1, 2, 0, 1, 2};
      start(0, 0, 0, 5, 0, 0, 1'b0);
      cyc(); cyc();
      arr_val = 16'd2;
      for (int i = 0; i < 6; i++) begin
         cyc();
         chk("R9", "immediate reload", int'(cnt_out), exp_imm[i]);
      end

      // R4 freeze mid-prescale, then resume without losing phase
      start(0, 0, 2, 9, 0, 20, 1'b1);
      repeat (4) cyc();
      chk("R4", "before freeze", int'(cnt_out), 1);
      cnt_en = 1'b0;
      for (int i = 0; i < 5; i++) begin
         cyc();
         chk("R4", "frozen counter", int'(cnt_out), 1);
         chk("R4", "frozen update flag", int'(upd_flag), 0);
      end
      cnt_en = 1'b1;
      cyc();
      chk("R4", "resume edge 1", int'(cnt_out), 1);
      cyc();
      chk("R4", "resume edge 2", int'(cnt_out), 2);

      // R10 restart mid-run with compare value 0: no compare flag
      start(0, 0, 0, 5, 3, 0, 1'b1);
      repeat (3) cyc();
      ug = 1'b1;
      cyc();
      ug = 1'b0;
      chk("R10", "restart count", int'(cnt_out), 0);
      chk("R10", "restart cc flag", int'(cc_flag), 0);
      chk("R10", "restart upd flag", int'(upd_flag), 1);

      // R6 output mode codes, reference from observed counter
      start(0, 0, 0, 9, 0, 4, 1'b1);
      for (int m = 0; m < 16; m++) begin
         oc_mode = m[3:0];
         for (int i = 0; i < 10; i++) begin
            int e;
            cyc();
            case (m)
               4: e = 0;
               5: e = 1;
               6: e = (int'(cnt_out) < 4) ? 1 : 0;
               7: e = (int'(cnt_out) < 4) ? 0 : 1;
               default: e = 0;
            endcase
            chk("R6", "output mode", int'(pwm_out), e);
         end
      end

      // R7 gating combinations
      oc_mode = 4'b0110;
      for (int g = 0; g < 4; g++) begin
         ch_en = g[0];
         moe = g[1];
         for (int i = 0; i < 10; i++) begin
            cyc();
            chk("R7", "pin gating", int'(pwm_out),
                (g == 3 && int'(cnt_out) < 4) ? 1 : 0);
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule